// File: doc/BRIEF.md
# Virtual Output Queue Input Buffer

This block is the cell buffer on the input side of one switch port. Every arriving fixed-size cell carries the number of the output it is bound for. The block keeps one logical queue for each output, so a cell stuck behind a busy output never holds back cells that an idle output could take. All queues share one cell memory. A linked free list hands out slots, and a next-pointer per slot chains each queue together.

A scheduler outside the block reads a request vector with one bit per non-empty queue. It may grant one output per cycle, and the block returns the head cell of that queue one cycle later. When few free slots remain, the block raises backpressure toward the sender, so that cells already in flight still fit. A cell that arrives while the memory is completely full is dropped, and the stored cells stay intact.

Top module: `voq_inbuf`

## Requirements
- R1: After reset, free_count equals DEPTH, req_vec is all zero, and out_valid, drop_pulse and grant_err are low.
- R2: A cell presented with in_valid while free_count is non-zero is stored in queue in_dest. On the next cycle free_count is one lower and bit in_dest of req_vec is set.
- R3: The cells of any one queue leave in exactly the order they were accepted.
- R4: A grant for queue g returns the oldest cell of queue g, whatever cells wait in other queues (no head-of-line blocking).
- R5: One cycle after an accepted grant, out_valid is high, out_dest equals the granted queue and out_cell holds that cell's data. out_valid is low in every other cycle.
- R6: When free_count is zero at the clock edge, an arriving cell is discarded even if a dequeue happens in the same cycle. drop_pulse is high for the next cycle, and the stored cells and their order are unchanged.
- R7: A grant naming an empty queue changes no state and produces no out_valid. grant_err is high for one cycle on the next cycle.
- R8: backpressure is high exactly when free_count is less than or equal to the bp_thresh input.
- R9: An accepted enqueue and an accepted dequeue in the same cycle are both carried out, and free_count is unchanged. This also holds when both target a queue holding one cell, and when one free slot remains.
- R10: Bit i of req_vec is high exactly when queue i holds at least one cell, and it reflects every enqueue and dequeue from the following cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Arriving cell present |
| in_dest | input | $clog2(N_OUT) | Destination output of the arriving cell |
| in_cell | input | CELL_W | Arriving cell data |
| bp_thresh | input | $clog2(DEPTH+1) | Backpressure threshold in free slots |
| grant_valid | input | 1 | Dequeue grant present |
| grant_dest | input | $clog2(N_OUT) | Queue named by the grant |
| out_valid | output | 1 | Dequeued cell present |
| out_dest | output | $clog2(N_OUT) | Queue the cell came from |
| out_cell | output | CELL_W | Dequeued cell data |
| req_vec | output | N_OUT | Non-empty flag of each queue |
| free_count | output | $clog2(DEPTH+1) | Number of free cell slots |
| backpressure | output | 1 | Stop request toward the sender |
| drop_pulse | output | 1 | An arriving cell was discarded |
| grant_err | output | 1 | A grant named an empty queue |

## Verification
The hardest states to reach are the ones where the free list and a queue change at once: a grant on a queue holding one cell while a new cell enters the same queue, and an enqueue plus a dequeue when exactly one slot, or no slot, is free. The stimulus gets there on purpose. It fills the memory cell by cell to fifteen slots, performs a combined enqueue and dequeue, then fills to zero and repeats the combined operation, so the dropped arrival and the accepted grant meet in one cycle. A per-queue scoreboard then drains every queue in interleaved order. This shows that neither the links nor the free list were corrupted.

// File: rtl/voq_pkg.sv
package voq_pkg;
    localparam int DEF_N_OUT  = 4;
    localparam int DEF_DEPTH  = 16;
    localparam int DEF_CELL_W = 16;

    typedef enum logic [1:0] {
        FL_IDLE  = 2'b00,
        FL_TAKE  = 2'b01,
        FL_GIVE  = 2'b10,
        FL_SWAP  = 2'b11
    } fl_op_e;

    function automatic fl_op_e fl_op(input logic take, input logic give);
        return fl_op_e'({give, take});
    endfunction
endpackage

// File: rtl/voq_cell_store.sv
module voq_cell_store #(
    parameter int DEPTH  = voq_pkg::DEF_DEPTH,
    parameter int CELL_W = voq_pkg::DEF_CELL_W,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [CELL_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [CELL_W-1:0] rd_data,
    input  logic              lk_a_en,
    input  logic [AW-1:0]     lk_a_addr,
    input  logic [AW-1:0]     lk_a_val,
    input  logic              lk_b_en,
    input  logic [AW-1:0]     lk_b_addr,
    input  logic [AW-1:0]     lk_b_val,
    input  logic [AW-1:0]     nx_a_addr,
    output logic [AW-1:0]     nx_a,
    input  logic [AW-1:0]     nx_b_addr,
    output logic [AW-1:0]     nx_b
);
    logic [CELL_W-1:0] cell_mem [DEPTH];
    logic [AW-1:0]     link_mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) cell_mem[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) link_mem[i] <= AW'((i + 1) % DEPTH);
        end else begin
            if (lk_a_en) link_mem[lk_a_addr] <= lk_a_val;
            if (lk_b_en) link_mem[lk_b_addr] <= lk_b_val;
        end
    end

    assign rd_data = cell_mem[rd_addr];
    assign nx_a    = link_mem[nx_a_addr];
    assign nx_b    = link_mem[nx_b_addr];
endmodule

// File: rtl/voq_qptr.sv
module voq_qptr #(
    parameter int N_OUT = voq_pkg::DEF_N_OUT,
    parameter int DEPTH = voq_pkg::DEF_DEPTH,
    localparam int AW   = $clog2(DEPTH),
    localparam int DW   = $clog2(N_OUT),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      enq_fire,
    input  logic [DW-1:0]             enq_q,
    input  logic [AW-1:0]             enq_slot,
    input  logic                      deq_fire,
    input  logic [DW-1:0]             deq_q,
    input  logic [AW-1:0]             deq_next,
    output logic [N_OUT-1:0][AW-1:0]  q_head,
    output logic [N_OUT-1:0][AW-1:0]  q_tail,
    output logic [N_OUT-1:0]          q_busy
);
    for (genvar g = 0; g < N_OUT; g++) begin : g_q
        logic [CW-1:0] cnt;
        logic          e_hit, d_hit;

        assign e_hit     = enq_fire && (enq_q == DW'(g));
        assign d_hit     = deq_fire && (deq_q == DW'(g));
        assign q_busy[g] = (cnt != '0);

        always_ff @(posedge clk) begin
            if (rst) begin
                cnt       <= '0;
                q_head[g] <= '0;
                q_tail[g] <= '0;
            end else begin
                cnt <= cnt + CW'(e_hit) - CW'(d_hit);
                if (e_hit) q_tail[g] <= enq_slot;
                if (d_hit) begin
                    q_head[g] <= (e_hit && cnt == CW'(1)) ? enq_slot : deq_next;
                end else if (e_hit && cnt == '0) begin
                    q_head[g] <= enq_slot;
                end
            end
        end
    end
endmodule

// File: rtl/voq_inbuf.sv
module voq_inbuf #(
    parameter int N_OUT  = voq_pkg::DEF_N_OUT,
    parameter int DEPTH  = voq_pkg::DEF_DEPTH,
    parameter int CELL_W = voq_pkg::DEF_CELL_W,
    localparam int AW    = $clog2(DEPTH),
    localparam int DW    = $clog2(N_OUT),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DW-1:0]     in_dest,
    input  logic [CELL_W-1:0] in_cell,
    input  logic [CW-1:0]     bp_thresh,
    input  logic              grant_valid,
    input  logic [DW-1:0]     grant_dest,
    output logic              out_valid,
    output logic [DW-1:0]     out_dest,
    output logic [CELL_W-1:0] out_cell,
    output logic [N_OUT-1:0]  req_vec,
    output logic [CW-1:0]     free_count,
    output logic              backpressure,
    output logic              drop_pulse,
    output logic              grant_err
);
    import voq_pkg::*;

    logic [AW-1:0] fl_head, fl_tail;
    logic [CW-1:0] fl_cnt;
    logic          enq_fire, deq_fire;
    logic [AW-1:0] deq_slot, nxt_free, nxt_deq;
    logic [CELL_W-1:0] rd_data;
    logic [N_OUT-1:0][AW-1:0] q_head, q_tail;
    logic [N_OUT-1:0] q_busy;
    logic          lk_a_en, lk_b_en;
    fl_op_e        op;

    assign enq_fire = in_valid && (fl_cnt != '0);
    assign deq_fire = grant_valid && q_busy[grant_dest];
    assign deq_slot = q_head[grant_dest];
    assign op       = fl_op(enq_fire, deq_fire);

    assign lk_a_en = enq_fire && q_busy[in_dest];
    assign lk_b_en = (op == FL_GIVE && fl_cnt != '0) || (op == FL_SWAP && fl_cnt != CW'(1));

    voq_cell_store #(.DEPTH(DEPTH), .CELL_W(CELL_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (enq_fire),
        .wr_addr   (fl_head),
        .wr_data   (in_cell),
        .rd_addr   (deq_slot),
        .rd_data   (rd_data),
        .lk_a_en   (lk_a_en),
        .lk_a_addr (q_tail[in_dest]),
        .lk_a_val  (fl_head),
        .lk_b_en   (lk_b_en),
        .lk_b_addr (fl_tail),
        .lk_b_val  (deq_slot),
        .nx_a_addr (fl_head),
        .nx_a      (nxt_free),
        .nx_b_addr (deq_slot),
        .nx_b      (nxt_deq)
    );

    voq_qptr #(.N_OUT(N_OUT), .DEPTH(DEPTH)) u_qptr (
        .clk      (clk),
        .rst      (rst),
        .enq_fire (enq_fire),
        .enq_q    (in_dest),
        .enq_slot (fl_head),
        .deq_fire (deq_fire),
        .deq_q    (grant_dest),
        .deq_next (nxt_deq),
        .q_head   (q_head),
        .q_tail   (q_tail),
        .q_busy   (q_busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fl_head <= '0;
            fl_tail <= AW'(DEPTH - 1);
            fl_cnt  <= CW'(DEPTH);
        end else begin
            case (op)
                FL_TAKE: begin
                    fl_head <= nxt_free;
                    fl_cnt  <= fl_cnt - CW'(1);
                end
                FL_GIVE: begin
                    if (fl_cnt == '0) fl_head <= deq_slot;
                    fl_tail <= deq_slot;
                    fl_cnt  <= fl_cnt + CW'(1);
                end
                FL_SWAP: begin
                    fl_head <= (fl_cnt == CW'(1)) ? deq_slot : nxt_free;
                    fl_tail <= deq_slot;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_dest   <= '0;
            out_cell   <= '0;
            drop_pulse <= 1'b0;
            grant_err  <= 1'b0;
        end else begin
            out_valid  <= deq_fire;
            if (deq_fire) begin
                out_dest <= grant_dest;
                out_cell <= rd_data;
            end
            drop_pulse <= in_valid && (fl_cnt == '0);
            grant_err  <= grant_valid && !q_busy[grant_dest];
        end
    end

    assign req_vec      = q_busy;
    assign free_count   = fl_cnt;
    assign backpressure = (fl_cnt <= bp_thresh);
endmodule

// File: rtl/voq_inbuf_chk.sv
module voq_inbuf_chk #(
    parameter int N_OUT = voq_pkg::DEF_N_OUT,
    parameter int DEPTH = voq_pkg::DEF_DEPTH,
    localparam int DW   = $clog2(N_OUT),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             grant_valid,
    input logic [DW-1:0]    grant_dest,
    input logic             out_valid,
    input logic [DW-1:0]    out_dest,
    input logic [N_OUT-1:0] req_vec,
    input logic [CW-1:0]    free_count,
    input logic             drop_pulse,
    input logic             grant_err
);
    logic [N_OUT-1:0] gsel;
    assign gsel = N_OUT'(1) << grant_dest;

    AST_DROP_ONLY_FULL: assert property (@(posedge clk) disable iff (rst)
        drop_pulse |-> ($past(in_valid) && $past(free_count) == '0));  // R6

    AST_ERR_ON_EMPTY: assert property (@(posedge clk) disable iff (rst)
        grant_err |-> ($past(grant_valid) && ($past(req_vec) & $past(gsel)) == '0));  // R7

    AST_OUT_NEEDS_GRANT: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($past(grant_valid) && ($past(req_vec) & $past(gsel)) != '0));  // R5

    AST_OUT_DEST_MATCH: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_dest == $past(grant_dest)));  // R5

    AST_NO_OUT_AND_ERR: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && grant_err));  // R7

    AST_FREE_STEP: assert property (@(posedge clk) disable iff (rst)
        (free_count == $past(free_count)) || (free_count == $past(free_count) + CW'(1))
        || (free_count + CW'(1) == $past(free_count)));  // R9

    AST_FREE_BOUND: assert property (@(posedge clk) disable iff (rst)
        free_count <= CW'(DEPTH));  // R2

    AST_ALL_FREE_IDLE: assert property (@(posedge clk) disable iff (rst)
        (free_count == CW'(DEPTH)) |-> (req_vec == '0));  // R10
endmodule

bind voq_inbuf voq_inbuf_chk #(.N_OUT(N_OUT), .DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .grant_valid (grant_valid),
    .grant_dest  (grant_dest),
    .out_valid   (out_valid),
    .out_dest    (out_dest),
    .req_vec     (req_vec),
    .free_count  (free_count),
    .drop_pulse  (drop_pulse),
    .grant_err   (grant_err)
);

// File: tb/test_voq_inbuf.sv
module test_voq_inbuf;
    localparam int N  = 4;
    localparam int D  = 16;
    localparam int CWD = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [1:0] in_dest = '0;
    logic [CWD-1:0] in_cell = '0;
    logic [4:0] bp_thresh = 5'd3;
    logic grant_valid = 1'b0;
    logic [1:0] grant_dest = '0;
    logic out_valid;
    logic [1:0] out_dest;
    logic [CWD-1:0] out_cell;
    logic [N-1:0] req_vec;
    logic [4:0] free_count;
    logic backpressure, drop_pulse, grant_err;

    int checks = 0;
    int errors = 0;
    int mfree = D;
    logic [CWD-1:0] mq [N][$];
    logic [CWD-1:0] exp_cell [$];
    logic [1:0]     exp_dest [$];
    logic [CWD-1:0] seq_val = 16'h1000;

    always #4 clk = ~clk;

    voq_inbuf i_voq_inbuf (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_dest(in_dest), .in_cell(in_cell),
        .bp_thresh(bp_thresh), .grant_valid(grant_valid), .grant_dest(grant_dest),
        .out_valid(out_valid), .out_dest(out_dest), .out_cell(out_cell), .req_vec(req_vec),
        .free_count(free_count), .backpressure(backpressure), .drop_pulse(drop_pulse),
        .grant_err(grant_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [N-1:0] model_req();
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) r[i] = (mq[i].size() != 0);
        return r;
    endfunction

    // Driver: one cycle; starts and ends at a falling edge.
    task automatic step(input bit en, input int d, input bit gv, input int g);
        bit exp_drop, exp_err;
        in_valid = en; in_dest = 2'(d); in_cell = seq_val;
        grant_valid = gv; grant_dest = 2'(g);
        exp_drop = en && (mfree == 0);
        exp_err  = gv && (mq[g].size() == 0);
        if (gv && mq[g].size() != 0) begin
            exp_cell.push_back(mq[g].pop_front());
            exp_dest.push_back(2'(g));
            mfree++;
        end
        if (en && !exp_drop) begin
            mq[d].push_back(seq_val);
            mfree--;
        end
        seq_val++;
        @(negedge clk);
        in_valid = 1'b0; grant_valid = 1'b0;
        chk(drop_pulse == exp_drop, "R6 drop_pulse", int'(drop_pulse), int'(exp_drop));
        chk(grant_err == exp_err, "R7 grant_err", int'(grant_err), int'(exp_err));
        chk(free_count == 5'(mfree), "R2/R9 free_count", int'(free_count), mfree);
        chk(req_vec == model_req(), "R10 req_vec", int'(req_vec), int'(model_req()));
        chk(backpressure == (mfree <= int'(bp_thresh)), "R8 backpressure",
            int'(backpressure), int'(mfree <= int'(bp_thresh)));
    endtask

    // Monitor: pops the scoreboard whenever a cell leaves (R3, R4, R5).
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_cell.size() == 0) begin
                chk(1'b0, "R5 unexpected out_valid", 1, 0);
            end else begin
                logic [CWD-1:0] ec;
                logic [1:0] ed;
                ec = exp_cell.pop_front();
                ed = exp_dest.pop_front();
                chk(out_cell == ec, "R3/R4 out_cell", int'(out_cell), int'(ec));
                chk(out_dest == ed, "R5 out_dest", int'(out_dest), int'(ed));
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(free_count == 5'(D), "R1 free_count", int'(free_count), D);
        chk(req_vec == '0, "R1 req_vec", int'(req_vec), 0);
        chk(!out_valid && !drop_pulse && !grant_err, "R1 pulses", int'(out_valid), 0);
        chk(backpressure == 1'b0, "R1 backpressure", int'(backpressure), 0);

        // R2 one cell per queue
        for (int i = 0; i < N; i++) step(1, i, 0, 0);
        // R4: load queue 0, then serve queue 2 and 3 past it
        for (int i = 0; i < 4; i++) step(1, 0, 0, 0);
        step(0, 0, 1, 2);
        step(0, 0, 1, 3);
        // R7 grant on empty queue
        step(0, 0, 1, 2);
        // R9 same queue holding one cell: enqueue and dequeue at once
        step(1, 1, 1, 1);
        step(0, 0, 1, 1);
        // fill up to one free slot (R8 threshold crossing along the way)
        while (mfree > 1) step(1, mfree % N, 0, 0);
        // R9 with exactly one free slot
        step(1, 2, 1, 0);
        // fill completely, then over-fill: R6
        step(1, 3, 0, 0);
        step(1, 1, 0, 0);
        step(1, 2, 0, 0);
        // R6 full with simultaneous dequeue: arrival still dropped
        step(1, 0, 1, 3);
        // drain everything interleaved (R3 order, R4 independence)
        while (mfree < D) begin
            for (int q = N - 1; q >= 0; q--) step(0, 0, 1, q);
        end
        // R7 after full drain
        step(0, 0, 1, 0);
        // R9 mixed traffic with change of threshold
        bp_thresh = 5'd10;
        for (int i = 0; i < 40; i++) step(1, (i * 3) % N, (i % 2) == 1, i % N);
        while (mfree < D) begin
            for (int q = 0; q < N; q++) step(0, 0, 1, q);
        end
        step(0, 0, 0, 0);
        chk(exp_cell.size() == 0, "R5 missing outputs", exp_cell.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule